// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Halt Wake

This block gathers every interrupt request of a small processor subsystem and presents one winner at a time to the CPU. Two sources sit outside the masking scheme: a non-maskable pin and a watchdog strobe. The maskable sources are six external pins and a parameterized number of single-cycle strobes from on-chip peripherals. Each pin is filtered for a minimum pulse width. It is then turned into a request by its own detection rule, and that rule is fixed for some pins and selectable for others. Edge requests are latched until the CPU acknowledges the presented vector. A level request follows its pin.

Each maskable source carries a 3-bit priority. A maskable source competes only while its priority is above the CPU's current mask level. The winner's vector number and level appear on the CPU side combinationally, and an acknowledge pulse retires it. A separate wake output releases a low-power halt. A request that lands during the short window in which the core is still entering halt is recorded, but it is marked as held and cannot wake the core by itself. Once a fresh request wakes the core, the held request and the fresh one are arbitrated together by priority.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The non-maskable pin (idle high) raises a request on a filtered falling edge when `nmi_both_edges`=0, and on either edge when it is 1. A pending non-maskable request always wins, is shown as vector 0 with level 7, and is not affected by `cpu_mask`.
- R2: A one-cycle `wdt_req` strobe latches a request that ignores `cpu_mask`. It is shown as vector 1 with level 7, ranks below the non-maskable source and above every maskable one.
- R3: Pin 0 is level-sensitive (active high) when `ext_mode[0]`=0. Its request then follows the filtered pin, and acknowledge does not remove it. When `ext_mode[0]`=1, a filtered rising edge latches a request that stays pending after the pin falls.
- R4: Pins 2 and 4 latch on a rising edge when their `ext_mode` bit is 0 and on a falling edge when it is 1. Pins 1, 3 and 5 latch on rising edges only, and their `ext_mode` bits have no effect.
- R5: A pin change counts only after the same new value has been sampled on `FAST_FILT`=4 consecutive clocks for the non-maskable pin and pin 0, and on `SLOW_FILT`=6 consecutive clocks for pins 1 to 5. Shorter pulses produce no request.
- R6: Maskable source m (pins m=0..5, then strobes m=6..9) takes its priority from `src_level[3m+2:3m]`. It is offered only when that level is strictly greater than `cpu_mask`, so level 0 never reaches the CPU.
- R7: Among offered sources, the highest level wins, and on a tie the lowest vector number wins. Vector numbers are 0 for the non-maskable source, 1 for the watchdog, 2+i for pin i and 8+j for strobe j. `irq_level` shows the winner's level.
- R8: `irq_ack` high in a cycle where `irq_valid` is high clears the latched request of the vector shown in that cycle, at that clock edge.
- R9: A request that becomes pending while `halt_entering` is high is held. `wake` is high only while `halt_active` is high and some offered request is not held.
- R10: Held marks are cleared once both `halt_entering` and `halt_active` are low. Held requests stay pending and are then served in priority order together with newer ones.
- R11: After reset, nothing is pending and `irq_valid` and `wake` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin | input | 1 | Synchronized non-maskable pin, idle high |
| nmi_both_edges | input | 1 | 1: non-maskable pin triggers on both edges |
| wdt_req | input | 1 | Watchdog request strobe |
| ext_pin | input | NUM_PIN | Synchronized external request pins |
| ext_mode | input | NUM_PIN | Per-pin detection select (see R3, R4) |
| int_req | input | NUM_INT | Peripheral request strobes |
| src_level | input | 3*(NUM_PIN+NUM_INT) | Packed priority per maskable source |
| cpu_mask | input | 3 | Current CPU mask level |
| irq_ack | input | 1 | Acknowledge of the presented vector |
| halt_entering | input | 1 | Core is on its way into halt |
| halt_active | input | 1 | Core is fully halted |
| irq_valid | output | 1 | A request is offered |
| irq_vec | output | VEC_W | Vector number of the winner |
| irq_level | output | 3 | Level of the winner |
| wake | output | 1 | Release the halt |

## Verification
The assertions assume that `halt_entering` and `halt_active` are never high together, that `irq_ack` is only raised while a vector is offered, and that the strobes are single-cycle pulses. The stimulus drives halt entry and full halt as separate phases, and it acknowledges only after it has checked that a vector is present. Pins are held for explicit cycle counts, both just under and at the filter length, and the mask and priority inputs change only between requests. A behavioural model is compared with the outputs on every cycle.

// File: rtl/prio_irq_pkg.sv
// Shared constants and the per-pin detection kind of the interrupt controller.
// Assumes pin indices are fixed by board wiring: the kind of each pin is a
// function of its index.
package prio_irq_pkg;

    localparam int LVL_W     = 3;   // priority level width (levels 0..7)
    localparam int FIXED_SRC = 2;   // non-maskable + watchdog
    localparam int RANK_W    = 4;   // level plus room for the two fixed ranks

    typedef enum logic [1:0] {
        PK_RISE         = 2'd0,     // rising edge only
        PK_LVL_OR_RISE  = 2'd1,     // level-high or rising edge
        PK_RISE_OR_FALL = 2'd2      // rising or falling edge
    } pin_kind_e;

    // Detection kind for a given external pin index.
    function automatic pin_kind_e kind_of(input int idx);
        case (idx)
            0:       return PK_LVL_OR_RISE;
            2, 4:    return PK_RISE_OR_FALL;
            default: return PK_RISE;
        endcase
    endfunction

endpackage

// File: rtl/prio_irq_filter.sv
// Pulse-width filter for one synchronized pin.
// The filtered value takes a new pin value only after FILT consecutive samples
// that differ from it. 'changed' pulses for one cycle together with the update.
// Assumes the pin is already synchronized to clk.
module prio_irq_filter #(
    parameter int   FILT = 4,
    parameter logic INIT = 1'b0,
    localparam int  CW   = $clog2(FILT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic stable,
    output logic changed
);

    logic [CW-1:0] cnt;

    // Count consecutive differing samples and commit after FILT of them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable  <= INIT;
            cnt     <= '0;
            changed <= 1'b0;
        end else begin
            changed <= 1'b0;
            if (raw == stable) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT - 1)) begin
                stable  <= raw;
                cnt     <= '0;
                changed <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/prio_irq_arb.sv
// Combinational priority arbiter.
// Source 0 (non-maskable) and source 1 (watchdog) get fixed ranks above any level.
// Maskable sources compete with their level when it exceeds the CPU mask.
// Assumes one packed 3-bit level per maskable source, in source order.
module prio_irq_arb
    import prio_irq_pkg::*;
#(
    parameter int  NUM_SRC  = 12,
    localparam int NUM_MASK = NUM_SRC - FIXED_SRC,
    localparam int VEC_W    = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]        req,
    input  logic [NUM_MASK*LVL_W-1:0] src_level,
    input  logic [LVL_W-1:0]          cpu_mask,
    output logic [NUM_SRC-1:0]        elig,
    output logic                      valid,
    output logic [VEC_W-1:0]          vec,
    output logic [LVL_W-1:0]          level
);

    logic [RANK_W-1:0] rank [NUM_SRC];

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_rank
        if (s == 0) begin : g_nmi
            assign rank[s] = RANK_W'(9);
            assign elig[s] = req[s];
        end else if (s == 1) begin : g_wdt
            assign rank[s] = RANK_W'(8);
            assign elig[s] = req[s];
        end else begin : g_mask
            logic [LVL_W-1:0] lv;
            assign lv      = src_level[(s-FIXED_SRC)*LVL_W +: LVL_W];
            assign rank[s] = {1'b0, lv};
            assign elig[s] = req[s] & (lv > cpu_mask);
        end
    end

    // Scan in index order and keep a source only on a strictly higher rank.
    always_comb begin
        logic [RANK_W-1:0] best;
        best  = '0;
        valid = 1'b0;
        vec   = '0;
        level = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (elig[s] && (!valid || rank[s] > best)) begin
                valid = 1'b1;
                best  = rank[s];
                vec   = VEC_W'(s);
                level = (s < FIXED_SRC) ? LVL_W'(7) : rank[s][LVL_W-1:0];
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
// Prioritized interrupt controller with halt wake.
// Filters and detects the non-maskable pin and the external pins, latches edge
// requests until acknowledged and arbitrates them with the watchdog and the
// peripheral strobes. It drives a wake output that ignores requests raised
// while the core was entering halt.
// Assumes synchronized pins, single-cycle strobes and halt_entering and
// halt_active never high together.
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter int  NUM_PIN   = 6,
    parameter int  NUM_INT   = 4,
    parameter int  FAST_FILT = 4,
    parameter int  SLOW_FILT = 6,
    localparam int NUM_MASK  = NUM_PIN + NUM_INT,
    localparam int NUM_SRC   = NUM_MASK + FIXED_SRC,
    localparam int VEC_W     = $clog2(NUM_SRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      nmi_pin,
    input  logic                      nmi_both_edges,
    input  logic                      wdt_req,
    input  logic [NUM_PIN-1:0]        ext_pin,
    input  logic [NUM_PIN-1:0]        ext_mode,
    input  logic [NUM_INT-1:0]        int_req,
    input  logic [NUM_MASK*LVL_W-1:0] src_level,
    input  logic [LVL_W-1:0]          cpu_mask,
    input  logic                      irq_ack,
    input  logic                      halt_entering,
    input  logic                      halt_active,
    output logic                      irq_valid,
    output logic [VEC_W-1:0]          irq_vec,
    output logic [LVL_W-1:0]          irq_level,
    output logic                      wake
);

    logic               nmi_stable, nmi_changed, nmi_evt;
    logic [NUM_PIN-1:0] pin_evt, pin_lvl, pin_lvl_rise;
    logic [NUM_SRC-1:0] evt, lvl_req, hold_lvl, req, elig, clr;
    logic [NUM_SRC-1:0] pend, held;

    // Non-maskable pin: filtered, idle high, falling edge or both edges.
    prio_irq_filter #(.FILT(FAST_FILT), .INIT(1'b1)) u_nmi_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (nmi_pin),
        .stable  (nmi_stable),
        .changed (nmi_changed)
    );
    assign nmi_evt = nmi_changed & (~nmi_stable | nmi_both_edges);

    // External pins: filter, then apply the detection rule of each index.
    for (genvar i = 0; i < NUM_PIN; i++) begin : g_pin
        localparam pin_kind_e KIND = kind_of(i);
        localparam int        FW   = (i == 0) ? FAST_FILT : SLOW_FILT;
        logic stable, changed;

        prio_irq_filter #(.FILT(FW), .INIT(1'b0)) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw     (ext_pin[i]),
            .stable  (stable),
            .changed (changed)
        );

        if (KIND == PK_LVL_OR_RISE) begin : g_lvl_rise
            assign pin_evt[i]      = ext_mode[i] & changed & stable;
            assign pin_lvl[i]      = ~ext_mode[i] & stable;
            assign pin_lvl_rise[i] = ~ext_mode[i] & changed & stable;
        end else if (KIND == PK_RISE_OR_FALL) begin : g_rise_fall
            assign pin_evt[i]      = changed & (ext_mode[i] ? ~stable : stable);
            assign pin_lvl[i]      = 1'b0;
            assign pin_lvl_rise[i] = 1'b0;
        end else begin : g_rise
            logic unused_mode;
            assign unused_mode     = ext_mode[i];
            assign pin_evt[i]      = changed & stable;
            assign pin_lvl[i]      = 1'b0;
            assign pin_lvl_rise[i] = 1'b0;
        end
    end

    assign evt      = {int_req, pin_evt, wdt_req, nmi_evt};
    assign lvl_req  = {{NUM_INT{1'b0}}, pin_lvl, 2'b00};
    assign hold_lvl = {{NUM_INT{1'b0}}, pin_lvl_rise, 2'b00};
    assign req      = pend | lvl_req;

    // Acknowledge retires the latched request of the vector shown this cycle.
    always_comb begin
        clr = '0;
        if (irq_ack && irq_valid) clr[irq_vec] = 1'b1;
    end

    // Latch edge requests; a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | evt;
    end

    // Mark requests raised during halt entry; drop marks once running.
    always_ff @(posedge clk) begin
        if (!rst_n)                              held <= '0;
        else if (!halt_entering && !halt_active) held <= '0;
        else held <= held | ((evt | hold_lvl) & {NUM_SRC{halt_entering}});
    end

    prio_irq_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .req       (req),
        .src_level (src_level),
        .cpu_mask  (cpu_mask),
        .elig      (elig),
        .valid     (irq_valid),
        .vec       (irq_vec),
        .level     (irq_level)
    );

    assign wake = halt_active & |(elig & ~held);

endmodule

// File: rtl/prio_irq_chk.sv
// Assertion checker for prio_irq_ctrl, attached with the bind below.
// Assumes irq_ack is only raised while a vector is offered.
module prio_irq_chk #(
    parameter int NUM_SRC = 12,
    parameter int VEC_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2:0]         cpu_mask,
    input logic               irq_valid,
    input logic [VEC_W-1:0]   irq_vec,
    input logic [2:0]         irq_level,
    input logic               irq_ack,
    input logic               halt_active,
    input logic               wake,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] evt
);

    // A maskable winner is always above the mask.
    assert_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && irq_vec > VEC_W'(1)) |-> (irq_level > cpu_mask));

    // A latched non-maskable request is always the one offered.
    assert_nmi_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pend[0] |-> (irq_valid && irq_vec == '0));

    // Wake only ever asserts during full halt.
    assert_wake_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> halt_active);

    // An acknowledged latched request is gone one cycle later unless re-raised.
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_valid && !evt[irq_vec]) |=> !pend[$past(irq_vec)]);

endmodule

bind prio_irq_ctrl prio_irq_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_mask    (cpu_mask),
    .irq_valid   (irq_valid),
    .irq_vec     (irq_vec),
    .irq_level   (irq_level),
    .irq_ack     (irq_ack),
    .halt_active (halt_active),
    .wake        (wake),
    .pend        (pend),
    .evt         (evt)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
// Self-checking bench: behavioural reference model compared every cycle plus
// directed checks per requirement.
module prio_irq_ctrl_tb;

    localparam int NP = 6;
    localparam int NI = 4;
    localparam int NM = NP + NI;
    localparam int NS = NM + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          nmi_pin = 1'b1;
    logic          nmi_both_edges = 1'b0;
    logic          wdt_req = 1'b0;
    logic [NP-1:0] ext_pin = '0;
    logic [NP-1:0] ext_mode = '0;
    logic [NI-1:0] int_req = '0;
    logic [NM*3-1:0] src_level = '0;
    logic [2:0]    cpu_mask = '0;
    logic          irq_ack = 1'b0;
    logic          halt_entering = 1'b0;
    logic          halt_active = 1'b0;
    logic          irq_valid;
    logic [3:0]    irq_vec;
    logic [2:0]    irq_level;
    logic          wake;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .nmi_both_edges(nmi_both_edges),
        .wdt_req(wdt_req), .ext_pin(ext_pin), .ext_mode(ext_mode), .int_req(int_req),
        .src_level(src_level), .cpu_mask(cpu_mask), .irq_ack(irq_ack),
        .halt_entering(halt_entering), .halt_active(halt_active),
        .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_level(irq_level), .wake(wake)
    );

    task automatic chk_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int mcnt [7];   // filter counters, index 6 = non-maskable pin
    bit mval [7];
    bit mchg [7];
    bit mpend [NS];
    bit mheld [NS];

    function automatic int lvl_of(input int s);
        return int'(src_level[(s-2)*3 +: 3]);
    endfunction

    function automatic void msel(output bit v, output int vec, output int lv, output bit wk);
        int best;
        v = 0; vec = 0; lv = 0; wk = 0; best = -1;
        for (int s = 0; s < NS; s++) begin
            bit r, e;
            int rk;
            r  = mpend[s] || (s == 2 && !ext_mode[0] && mval[0]);
            rk = (s == 0) ? 9 : (s == 1) ? 8 : lvl_of(s);
            e  = r && (s < 2 || lvl_of(s) > int'(cpu_mask));
            if (e && rk > best) begin
                v = 1; vec = s; best = rk; lv = (s < 2) ? 7 : rk;
            end
            if (e && !mheld[s] && halt_active) wk = 1;
        end
    endfunction

    always @(posedge clk) begin : mdl
        bit v, wk;
        int vec, lv;
        bit ev [NS];
        bit hx [NS];
        if (!rst_n) begin
            for (int k = 0; k < 7; k++) begin
                mcnt[k] = 0; mval[k] = (k == 6); mchg[k] = 0;
            end
            for (int s = 0; s < NS; s++) begin
                mpend[s] = 0; mheld[s] = 0;
            end
        end else begin
            msel(v, vec, lv, wk);
            for (int s = 0; s < NS; s++) begin
                ev[s] = 0; hx[s] = 0;
            end
            ev[0] = mchg[6] && (!mval[6] || nmi_both_edges);
            ev[1] = wdt_req;
            for (int i = 0; i < NP; i++) begin
                if (i == 0) begin
                    ev[2] = ext_mode[0] && mchg[0] && mval[0];
                    hx[2] = !ext_mode[0] && mchg[0] && mval[0];
                end else if (i == 2 || i == 4) begin
                    ev[2+i] = mchg[i] && (ext_mode[i] ? !mval[i] : mval[i]);
                end else begin
                    ev[2+i] = mchg[i] && mval[i];
                end
            end
            for (int j = 0; j < NI; j++) ev[2+NP+j] = int_req[j];
            if (irq_ack && v) mpend[vec] = 0;
            for (int s = 0; s < NS; s++) begin
                if (ev[s]) mpend[s] = 1;
                if (!halt_entering && !halt_active) mheld[s] = 0;
                else if (halt_entering && (ev[s] || hx[s])) mheld[s] = 1;
            end
            for (int k = 0; k < 7; k++) begin
                bit raw;
                int f;
                raw = (k == 6) ? nmi_pin : ext_pin[k];
                f   = (k == 0 || k == 6) ? 4 : 6;
                mchg[k] = 0;
                if (raw == mval[k]) mcnt[k] = 0;
                else if (mcnt[k] == f - 1) begin
                    mval[k] = raw; mcnt[k] = 0; mchg[k] = 1;
                end else mcnt[k] = mcnt[k] + 1;
            end
        end
    end

    // Compare the outputs against the model away from the active edge.
    always @(negedge clk) begin
        bit v, wk;
        int vec, lv;
        if (rst_n) begin
            msel(v, vec, lv, wk);
            chk_eq("R6 valid (model)", int'(irq_valid), int'(v));
            if (v) begin
                chk_eq("R7 vector (model)", int'(irq_vec), vec);
                chk_eq("R7 level (model)", int'(irq_level), lv);
            end
            chk_eq("R9 wake (model)", int'(wake), int'(wk));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic strobe(input logic [NI-1:0] m);
        int_req = m;
        step(1);
        int_req = '0;
        step(1);
    endtask

    task automatic ack();
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
    endtask

    task automatic set_lvl(input int m, input int lv);
        src_level[m*3 +: 3] = 3'(lv);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // pins 0..5 then strobes 0..3
        set_lvl(0, 4); set_lvl(1, 2); set_lvl(2, 4); set_lvl(3, 1); set_lvl(4, 3); set_lvl(5, 2);
        set_lvl(6, 3); set_lvl(7, 5); set_lvl(8, 5); set_lvl(9, 0);
        step(3);
        rst_n = 1'b1;
        step(1);
        chk_eq("R11 valid after reset", int'(irq_valid), 0);
        chk_eq("R11 wake after reset", int'(wake), 0);

        // R7/R8 single strobe, acknowledge
        strobe(4'b0001);
        chk_eq("R7 strobe0 vector", int'(irq_vec), 8);
        chk_eq("R7 strobe0 level", int'(irq_level), 3);
        ack();
        chk_eq("R8 cleared on ack", int'(irq_valid), 0);

        // R6 masking
        cpu_mask = 3'd3;
        strobe(4'b0001);
        chk_eq("R6 level equal to mask blocked", int'(irq_valid), 0);
        cpu_mask = 3'd2;
        step(1);
        chk_eq("R6 level above mask offered", int'(irq_vec), 8);
        ack();
        cpu_mask = 3'd0;
        strobe(4'b1000);
        chk_eq("R6 level zero never offered", int'(irq_valid), 0);

        // R7 tie, then higher level
        strobe(4'b0110);
        chk_eq("R7 tie lowest index", int'(irq_vec), 9);
        ack();
        chk_eq("R7 tie second", int'(irq_vec), 10);
        ack();
        strobe(4'b0011);
        chk_eq("R7 higher level first", int'(irq_vec), 9);
        ack();
        chk_eq("R7 lower level next", int'(irq_vec), 8);
        ack();
        chk_eq("R8 all served", int'(irq_valid), 0);

        // R1/R5 non-maskable pin
        cpu_mask = 3'd7;
        nmi_pin = 1'b0; step(3); nmi_pin = 1'b1; step(10);
        chk_eq("R5 short nmi pulse ignored", int'(irq_valid), 0);
        nmi_pin = 1'b0; step(4); nmi_pin = 1'b1; step(2);
        chk_eq("R1 nmi falling edge vector", int'(irq_vec), 0);
        chk_eq("R1 nmi level", int'(irq_level), 7);
        ack();
        step(8);
        chk_eq("R1 nmi rise ignored by default", int'(irq_valid), 0);
        nmi_both_edges = 1'b1;
        nmi_pin = 1'b0; step(6);
        chk_eq("R1 nmi fall with both edges", int'(irq_vec), 0);
        ack();
        nmi_pin = 1'b1; step(6);
        chk_eq("R1 nmi rise with both edges", int'(irq_valid), 1);
        ack();
        nmi_both_edges = 1'b0;

        // R2 watchdog over a maskable request, ignoring the mask
        strobe(4'b0010);
        wdt_req = 1'b1; step(1); wdt_req = 1'b0; step(1);
        chk_eq("R2 watchdog vector", int'(irq_vec), 1);
        chk_eq("R2 watchdog level", int'(irq_level), 7);
        ack();
        chk_eq("R2 maskable stays masked", int'(irq_valid), 0);
        cpu_mask = 3'd0; step(1);
        chk_eq("R2 maskable after unmask", int'(irq_vec), 9);
        ack();

        // R3 pin 0 level then edge mode
        ext_pin[0] = 1'b1; step(6);
        chk_eq("R3 level request vector", int'(irq_vec), 2);
        chk_eq("R3 level request level", int'(irq_level), 4);
        ack();
        chk_eq("R3 level survives ack", int'(irq_vec), 2);
        ext_pin[0] = 1'b0; step(6);
        chk_eq("R3 level removed with pin", int'(irq_valid), 0);
        ext_mode[0] = 1'b1;
        ext_pin[0] = 1'b1; step(6); ext_pin[0] = 1'b0; step(6);
        chk_eq("R3 edge latched", int'(irq_vec), 2);
        ack();
        chk_eq("R3 edge cleared by ack", int'(irq_valid), 0);

        // R4 selectable and fixed edge pins
        ext_mode[2] = 1'b1;
        ext_pin[2] = 1'b1; step(8);
        chk_eq("R4 pin2 rise ignored in falling mode", int'(irq_valid), 0);
        ext_pin[2] = 1'b0; step(8);
        chk_eq("R4 pin2 falling edge", int'(irq_vec), 4);
        ack();
        ext_mode[1] = 1'b1;
        ext_pin[1] = 1'b1; step(8);
        chk_eq("R4 pin1 rising despite mode bit", int'(irq_vec), 3);
        ack();
        ext_pin[1] = 1'b0; step(8);
        chk_eq("R4 pin1 falling ignored", int'(irq_valid), 0);

        // R5 slow filter on pin 3
        ext_pin[3] = 1'b1; step(5); ext_pin[3] = 1'b0; step(10);
        chk_eq("R5 five-cycle pulse ignored", int'(irq_valid), 0);
        ext_pin[3] = 1'b1; step(6); ext_pin[3] = 1'b0; step(2);
        chk_eq("R5 six-cycle pulse taken", int'(irq_vec), 5);
        ack();
        step(8);

        // R9/R10 request held during halt entry
        halt_entering = 1'b1;
        strobe(4'b0010);
        halt_entering = 1'b0;
        halt_active = 1'b1;
        step(2);
        chk_eq("R9 held request does not wake", int'(wake), 0);
        strobe(4'b0001);
        chk_eq("R9 new request wakes", int'(wake), 1);
        halt_active = 1'b0;
        step(1);
        chk_eq("R10 held higher level first", int'(irq_vec), 9);
        ack();
        chk_eq("R10 newer request next", int'(irq_vec), 8);
        ack();
        chk_eq("R10 all served", int'(irq_valid), 0);
        halt_active = 1'b1;
        step(1);
        chk_eq("R10 no stale wake", int'(wake), 0);
        halt_active = 1'b0;

        step(5);
        finish_run();
    end

endmodule